// File: doc/BRIEF.md
# HDCP Master Key Accumulator

This block forms the transmitter-side shared master key of an HDCP 1.x link. Software first loads the receiver's 40-bit key selection vector into the block one byte at a time, low byte first. A single-cycle start command then makes the block walk an external key store holding forty 56-bit private keys. It fetches one word per cycle over a synchronous read port. Every key whose selector bit is set is added into a 56-bit running sum that wraps modulo 2^56.

Alongside the sum the block grades the loaded selector. The selector is well formed only when it holds exactly twenty ones. The block also fetches the transmitter's own selection vector from a padded word of the same store when asked, and hands it back one byte at a time. A done flag marks the key as ready. A separate ready flag marks the transmitter vector as available.

Top module: `hdcpkm_top`

## Requirements
- R1: After reset, `done`, `bksv_ok`, `ksv_rdy` and `key_rd_en` are all 0.
- R2: Each `bksv_wr` pulse while idle shifts `bksv_byte` into the selector register. After five writes the first byte written holds bits 7:0 and the fifth holds bits 39:32. Writes made while a computation or vector fetch is running are ignored.
- R3: `km` equals the sum modulo 2^56 of every private key N (store word address N, 0 to 39) for which selector bit N is 1.
- R4: The store has one cycle of read latency. The block presents addresses 0 to 39 on consecutive cycles with `key_rd_en` high. `done` rises 41 clock edges after the edge that sampled the accepted start.
- R5: `done` clears on the edge that accepts a start. Otherwise it holds its value.
- R6: `bksv_ok` is 1 exactly when the loaded selector holds twenty ones and twenty zeros. It is captured when the start is accepted. The key is computed whether or not the selector is well formed.
- R7: A start command that arrives while the block is busy is ignored and does not disturb the running computation or its latency.
- R8: A `ksv_req` pulse while idle reads store word 40 and keeps bits 39:0; bits 55:40 are discarded. `ksv_rdy` is set two edges after the request edge, with byte 0 (bits 7:0) on `ksv_byte`. Each `ksv_pop` while ready advances to the next higher byte, and the fifth pop wraps back to byte 0.
- R9: A `ksv_req` while busy is ignored. When `start` and `ksv_req` arrive together while idle, the start wins and the vector request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle command to compute the key |
| bksv_wr | input | 1 | Load strobe for one selector byte |
| bksv_byte | input | 8 | Selector byte, low byte first |
| ksv_req | input | 1 | Single-cycle request for the transmitter vector |
| ksv_pop | input | 1 | Advance to the next transmitter vector byte |
| key_rd_en | output | 1 | Key store read enable |
| key_addr | output | 6 | Key store word address |
| key_data | input | 56 | Key store read data, one cycle after the address |
| km | output | 56 | Accumulated master key |
| done | output | 1 | Key ready |
| bksv_ok | output | 1 | Selector well formed (meaningful when `done` is 1) |
| ksv_byte | output | 8 | Current transmitter vector byte |
| ksv_rdy | output | 1 | Transmitter vector available |

## Verification
The assertions watch on every cycle that store addresses step by one with no gaps and never pass word 40. They also check that `done` rises exactly 41 edges after an accepted start, clears on acceptance and holds otherwise. Further properties check that `bksv_ok` moves only on acceptance and that the vector byte holds still unless popped. The arithmetic of the key can only be shown by the bench's scenarios: a sweep of every single-bit selector, dense patterns whose sums wrap, and selectors with nineteen, twenty and twenty-one ones. The same holds for ignored writes and commands, whose effect appears only in later results.

// File: rtl/hdcpkm_pkg.sv
package hdcpkm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_e;

endpackage

// File: rtl/hdcpkm_bksv_reg.sv
module hdcpkm_bksv_reg #(
  parameter int SEL_W  = 40,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [SEL_W-1:0]  sel,
  output logic              well_formed
);
  localparam int HALF = SEL_W / 2;
  localparam int CNT_W = $clog2(SEL_W + 1);

  logic [CNT_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (load_en) begin
      sel <= {byte_in, sel[SEL_W-1:BYTE_W]};
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < SEL_W; i++) begin
      ones = ones + CNT_W'(sel[i]);
    end
    well_formed = (ones == CNT_W'(HALF));
  end

endmodule

// File: rtl/hdcpkm_seq.sv
module hdcpkm_seq
  import hdcpkm_pkg::*;
#(
  parameter int NKEYS  = 40,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ksv_req,
  output logic              accept_key,
  output logic              accept_ksv,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pipe_vld,
  output logic [ADDR_W-1:0] pipe_idx
);
  localparam logic [ADDR_W-1:0] LAST_KEY = ADDR_W'(NKEYS - 1);
  localparam logic [ADDR_W-1:0] KSV_ADDR = ADDR_W'(NKEYS);

  sq_state_e         state;
  logic [ADDR_W-1:0] last_addr;

  assign busy       = (state != SQ_IDLE);
  assign accept_key = start && (state == SQ_IDLE);
  assign accept_ksv = ksv_req && !start && (state == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      last_addr <= '0;
      pipe_vld  <= 1'b0;
      pipe_idx  <= '0;
    end else begin
      pipe_vld <= rd_en;
      pipe_idx <= rd_addr;
      case (state)
        SQ_IDLE: begin
          if (accept_key) begin
            rd_en     <= 1'b1;
            rd_addr   <= '0;
            last_addr <= LAST_KEY;
            state     <= SQ_ISSUE;
          end else if (accept_ksv) begin
            rd_en     <= 1'b1;
            rd_addr   <= KSV_ADDR;
            last_addr <= KSV_ADDR;
            state     <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (rd_addr == last_addr) begin
            rd_en <= 1'b0;
            state <= SQ_DRAIN;
          end else begin
            rd_addr <= rd_addr + 1'b1;
          end
        end
        SQ_DRAIN: state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdcpkm_acc.sv
module hdcpkm_acc #(
  parameter int KEY_W  = 56,
  parameter int NKEYS  = 40,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              pipe_vld,
  input  logic [ADDR_W-1:0] pipe_idx,
  input  logic [KEY_W-1:0]  key_word,
  input  logic [NKEYS-1:0]  sel,
  input  logic              sel_ok,
  output logic [KEY_W-1:0]  sum,
  output logic              done,
  output logic              valid
);
  localparam logic [ADDR_W-1:0] LAST_KEY = ADDR_W'(NKEYS - 1);

  logic is_key;
  assign is_key = pipe_vld && (pipe_idx <= LAST_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      done  <= 1'b0;
      valid <= 1'b0;
    end else if (clear) begin
      sum   <= '0;
      done  <= 1'b0;
      valid <= sel_ok;
    end else if (is_key) begin
      if (sel[pipe_idx]) begin
        sum <= sum + key_word;
      end
      if (pipe_idx == LAST_KEY) begin
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdcpkm_ksv_out.sv
module hdcpkm_ksv_out #(
  parameter int SEL_W  = 40,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              pipe_vld,
  input  logic [ADDR_W-1:0] pipe_idx,
  input  logic [SEL_W-1:0]  word,
  input  logic              pop,
  output logic [BYTE_W-1:0] byte_out,
  output logic              rdy
);
  localparam int NBYTES = SEL_W / BYTE_W;
  localparam int PTR_W  = $clog2(NBYTES);
  localparam logic [ADDR_W-1:0] KSV_ADDR = ADDR_W'(SEL_W);
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(NBYTES - 1);

  logic [BYTE_W-1:0] held [NBYTES];
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  nptr;
  logic              capture;

  assign capture = pipe_vld && (pipe_idx == KSV_ADDR);
  assign nptr    = (ptr == LAST_PTR) ? '0 : ptr + 1'b1;

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    always_ff @(posedge clk) begin
      if (rst) begin
        held[g] <= '0;
      end else if (capture) begin
        held[g] <= word[g*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      byte_out <= '0;
      rdy      <= 1'b0;
    end else if (capture) begin
      ptr      <= '0;
      byte_out <= word[BYTE_W-1:0];
      rdy      <= 1'b1;
    end else if (clear) begin
      rdy <= 1'b0;
    end else if (pop && rdy) begin
      ptr      <= nptr;
      byte_out <= held[nptr];
    end
  end

endmodule

// File: rtl/hdcpkm_top.sv
module hdcpkm_top #(
  parameter int KEY_W  = 56,
  parameter int NKEYS  = 40,
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bksv_wr,
  input  logic [BYTE_W-1:0] bksv_byte,
  input  logic              ksv_req,
  input  logic              ksv_pop,
  output logic              key_rd_en,
  output logic [ADDR_W-1:0] key_addr,
  input  logic [KEY_W-1:0]  key_data,
  output logic [KEY_W-1:0]  km,
  output logic              done,
  output logic              bksv_ok,
  output logic [BYTE_W-1:0] ksv_byte,
  output logic              ksv_rdy
);
  localparam int SEL_W = NKEYS;

  logic              acc_go;
  logic              ksv_go;
  logic              seq_busy;
  logic              pipe_vld;
  logic [ADDR_W-1:0] pipe_idx;
  logic [SEL_W-1:0]  sel;
  logic              sel_ok;

  hdcpkm_bksv_reg #(.SEL_W(SEL_W), .BYTE_W(BYTE_W)) u_sel (
    .clk(clk), .rst(rst), .load_en(bksv_wr && !seq_busy), .byte_in(bksv_byte),
    .sel(sel), .well_formed(sel_ok)
  );

  hdcpkm_seq #(.NKEYS(NKEYS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .ksv_req(ksv_req),
    .accept_key(acc_go), .accept_ksv(ksv_go), .busy(seq_busy),
    .rd_en(key_rd_en), .rd_addr(key_addr), .pipe_vld(pipe_vld), .pipe_idx(pipe_idx)
  );

  hdcpkm_acc #(.KEY_W(KEY_W), .NKEYS(NKEYS), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .clear(acc_go), .pipe_vld(pipe_vld), .pipe_idx(pipe_idx),
    .key_word(key_data), .sel(sel), .sel_ok(sel_ok),
    .sum(km), .done(done), .valid(bksv_ok)
  );

  hdcpkm_ksv_out #(.SEL_W(SEL_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ksv (
    .clk(clk), .rst(rst), .clear(ksv_go), .pipe_vld(pipe_vld), .pipe_idx(pipe_idx),
    .word(key_data[SEL_W-1:0]), .pop(ksv_pop), .byte_out(ksv_byte), .rdy(ksv_rdy)
  );

endmodule

// File: rtl/hdcpkm_chk.sv
module hdcpkm_chk #(
  parameter int NKEYS  = 40,
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_go,
  input logic              key_rd_en,
  input logic [ADDR_W-1:0] key_addr,
  input logic              done,
  input logic              bksv_ok,
  input logic              ksv_pop,
  input logic              ksv_rdy,
  input logic [BYTE_W-1:0] ksv_byte
);
  localparam int LAT = NKEYS + 1;

  logic [7:0] since_go;
  logic       run;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_go <= '0;
      run      <= 1'b0;
    end else if (acc_go) begin
      since_go <= '0;
      run      <= 1'b1;
    end else if (run) begin
      if (since_go != 8'hFF) since_go <= since_go + 1'b1;
      if (done) run <= 1'b0;
    end
  end

  // R4: addresses advance one per cycle without gaps
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    key_rd_en && $past(key_rd_en) |-> key_addr == $past(key_addr) + 1'b1);

  // R4/R8: never past the vector word
  p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
    key_rd_en |-> key_addr <= ADDR_W'(NKEYS));

  // R4: fixed latency
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> run && since_go == 8'(LAT));

  // R5: cleared on acceptance
  p_done_clear_r5: assert property (@(posedge clk) disable iff (rst)
    acc_go |=> !done);

  // R5: held otherwise
  p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
    done && !acc_go |=> done);

  // R6: verdict only moves on acceptance
  p_ok_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_go |=> $stable(bksv_ok));

  // R8: vector byte holds unless popped
  p_ksv_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ksv_rdy && !ksv_pop |=> $stable(ksv_byte));

endmodule

bind hdcpkm_top hdcpkm_chk #(.NKEYS(NKEYS), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .acc_go(acc_go), .key_rd_en(key_rd_en), .key_addr(key_addr),
  .done(done), .bksv_ok(bksv_ok), .ksv_pop(ksv_pop), .ksv_rdy(ksv_rdy), .ksv_byte(ksv_byte)
);

// File: tb/hdcpkm_top_bench.sv
`timescale 1ns/1ps
module hdcpkm_top_bench;
  localparam int KEY_W = 56;
  localparam int NKEYS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bksv_wr = 1'b0;
  logic [7:0]  bksv_byte = '0;
  logic        ksv_req = 1'b0;
  logic        ksv_pop = 1'b0;
  logic        key_rd_en;
  logic [5:0]  key_addr;
  logic [55:0] key_data = '0;
  logic [55:0] km;
  logic        done;
  logic        bksv_ok;
  logic [7:0]  ksv_byte;
  logic        ksv_rdy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hdcpkm_top u_hdcpkm_top (
    .clk(clk), .rst(rst), .start(start), .bksv_wr(bksv_wr), .bksv_byte(bksv_byte),
    .ksv_req(ksv_req), .ksv_pop(ksv_pop), .key_rd_en(key_rd_en), .key_addr(key_addr),
    .key_data(key_data), .km(km), .done(done), .bksv_ok(bksv_ok),
    .ksv_byte(ksv_byte), .ksv_rdy(ksv_rdy)
  );

  localparam logic [55:0] TOP_WORD = {16'hBEEF, 40'h12_3456_789A};

  function automatic logic [55:0] key_of(int i);
    logic [63:0] v;
    v = 64'hFEDC_BA98_7654_3210 ^ (64'(i) * 64'h0000_9E37_79B9_7F4B);
    return v[55:0];
  endfunction

  always @(posedge clk) begin
    if (key_rd_en) key_data <= (key_addr == 6'd40) ? TOP_WORD : key_of(int'(key_addr));
  end

  function automatic logic [55:0] exp_km(logic [39:0] b);
    logic [55:0] s = '0;
    for (int i = 0; i < NKEYS; i++) if (b[i]) s = s + key_of(i);
    return s;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [39:0] b);
    for (int k = 0; k < 5; k++) begin
      bksv_wr = 1'b1;
      bksv_byte = b[8*k +: 8];
      step();
    end
    bksv_wr = 1'b0;
  endtask

  // disturb: write other bytes and pulse start while busy (R2, R7)
  task automatic run(logic [39:0] b, bit do_load, bit disturb);
    int cnt;
    if (do_load) load(b);
    start = 1'b1;
    step();
    start = 1'b0;
    chk(done == 1'b0, "R5 done cleared on start", 64'(done), 64'd0);
    cnt = 0;
    while (!done && cnt < 100) begin
      if (disturb && cnt >= 2 && cnt < 7) begin
        bksv_wr = 1'b1;
        bksv_byte = 8'h3C;
      end else begin
        bksv_wr = 1'b0;
      end
      start = (disturb && cnt == 10);
      step();
      cnt++;
    end
    bksv_wr = 1'b0;
    start = 1'b0;
    chk(cnt == 41, "R4 latency", 64'(cnt), 64'd41);
    chk(km == exp_km(b), "R3 key sum", 64'(km), 64'(exp_km(b)));
    chk(bksv_ok == ($countones(b) == 20), "R6 selector verdict", 64'(bksv_ok),
        64'($countones(b) == 20));
    step();
    chk(done == 1'b1, "R5 done holds", 64'(done), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] vb [5];
    vb[0] = 8'h9A; vb[1] = 8'h78; vb[2] = 8'h56; vb[3] = 8'h34; vb[4] = 8'h12;
    repeat (4) step();
    rst = 1'b0;
    step();
    // R1
    chk(done == 0, "R1 done", 64'(done), 0);
    chk(bksv_ok == 0, "R1 bksv_ok", 64'(bksv_ok), 0);
    chk(ksv_rdy == 0, "R1 ksv_rdy", 64'(ksv_rdy), 0);
    chk(key_rd_en == 0, "R1 key_rd_en", 64'(key_rd_en), 0);

    // R3: every single-bit selector picks key N
    for (int n = 0; n < NKEYS; n++) run(40'd1 << n, 1'b1, 1'b0);

    // R3/R6: dense and boundary patterns
    run(40'h55_5555_5555, 1'b1, 1'b0);
    run(40'hFF_FFF0_0000, 1'b1, 1'b0);
    run(40'h00_000F_FFFF, 1'b1, 1'b0);
    run(40'hA5_A5A5_A5A5, 1'b1, 1'b0);
    run(40'h00_001F_FFFF, 1'b1, 1'b0);
    run(40'h00_0007_FFFF, 1'b1, 1'b0);
    run(40'h00_0000_0000, 1'b1, 1'b0);
    run(40'hFF_FFFF_FFFF, 1'b1, 1'b0);

    // R2/R7: writes and start while busy ignored; rerun without loading
    run(40'hC3_3C96_69A5, 1'b1, 1'b1);
    run(40'hC3_3C96_69A5, 1'b0, 1'b0);

    // R2: byte order of the shift load
    run(40'h01_0000_0080, 1'b1, 1'b0);

    // R8: transmitter vector readout
    ksv_req = 1'b1;
    step();
    ksv_req = 1'b0;
    step();
    chk(ksv_rdy == 0, "R8 not ready one edge after", 64'(ksv_rdy), 0);
    step();
    chk(ksv_rdy == 1, "R8 ready", 64'(ksv_rdy), 1);
    for (int k = 0; k < 6; k++) begin
      chk(ksv_byte == vb[k % 5], "R8 vector byte", 64'(ksv_byte), 64'(vb[k % 5]));
      ksv_pop = 1'b1;
      step();
      ksv_pop = 1'b0;
    end
    // now at byte 1 after six pops; pop back to byte 0 state check later
    for (int k = 0; k < 4; k++) begin
      ksv_pop = 1'b1;
      step();
    end
    ksv_pop = 1'b0;
    chk(ksv_byte == vb[0], "R8 wrap to byte 0", 64'(ksv_byte), 64'(vb[0]));

    // R9: ksv_req while busy ignored
    load(40'h55_5555_5555);
    start = 1'b1;
    step();
    start = 1'b0;
    step();
    ksv_req = 1'b1;
    step();
    ksv_req = 1'b0;
    repeat (45) step();
    chk(ksv_rdy == 1, "R9 request while busy ignored", 64'(ksv_rdy), 1);
    chk(key_rd_en == 0, "R9 no extra fetch", 64'(key_rd_en), 0);

    // R9: start wins over simultaneous request
    start = 1'b1;
    ksv_req = 1'b1;
    step();
    start = 1'b0;
    ksv_req = 1'b0;
    repeat (41) step();
    chk(done == 1, "R9 start took priority", 64'(done), 1);
    chk(ksv_rdy == 1, "R9 request dropped", 64'(ksv_rdy), 1);
    chk(km == exp_km(40'h55_5555_5555), "R9 key after tie", 64'(km),
        64'(exp_km(40'h55_5555_5555)));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule